// File: doc/BRIEF.md
# DTMF Steering and Output Latch

This block sits behind a dual-tone detector. The detector gives it an early-detect flag and a 4-bit candidate key code. Digital guard counters replace the usual resistor-capacitor steering network. A tone must stay present for a programmable number of clock cycles before its code is taken. A registered tone is only released after the flag has stayed absent for a second programmable number of cycles. Short bursts are therefore rejected, and brief dropouts inside a tone do not split one key press into two.

When a tone is accepted, its code is written into an output latch. A delayed-steering flag rises a fixed two cycles later, after the latch has settled. The latch keeps the last accepted code until a new tone is accepted. It also survives power-down and the pause between keys.

An inhibit input hides the four extended keys. While it is high, the detector's flag is ignored for their codes. A power-down input clears every timer and the flag but leaves the latch intact. An output-enable input decides whether the data bus is driven. The bus is a plain output with a separate drive-enable, meant for a three-state pad outside the block.

Top module: `dtmf_steer`

## Requirements
- R1: A detect flag that stays high for fewer consecutive cycles than the tone guard count leaves the latch and the delayed-steering flag unchanged.
- R2: When the detect flag has been high for exactly the tone guard count of consecutive cycles, the code present in that last cycle is written into the latch at that clock edge.
- R3: The delayed-steering flag rises exactly two clock edges after the edge that updated the latch, provided the tone is still registered.
- R4: While a tone is registered, a detect-flag absence shorter than the pause guard count keeps the delayed-steering flag high, and no new code is taken into the latch.
- R5: After the detect flag has been absent for the pause guard count of consecutive cycles, the delayed-steering flag falls at that edge, and a following tone can be accepted.
- R6: The extended keys have the codes 4'b1101, 4'b1110, 4'b1111 and 4'b0000. While inhibit is high, a detect flag that comes with one of these codes is treated as absent. Other codes are accepted as usual.
- R7: With output enable high, the drive-enable output is high and the data output shows the latch. With output enable low, the drive-enable is low and the data output reads 4'b0000.
- R8: While power-down is high, no tone is accepted. The delayed-steering flag is low from the first edge onward, and the latch keeps its contents.
- R9: After reset, the latch holds 4'b0000 and the delayed-steering flag is low.
- R10: A guard count of zero behaves as a count of one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| det_i | input | 1 | Early tone-detect flag from the detector |
| code_i | input | 4 | Candidate key code |
| tone_guard_i | input | CW | Required tone-present cycles |
| pause_guard_i | input | CW | Required tone-absent cycles |
| inhibit_i | input | 1 | Ignore the extended keys when high |
| pwr_dn_i | input | 1 | Power-down, active high |
| out_en_i | input | 1 | Output enable for the data bus |
| data_o | output | 4 | Latched code, gated by the output enable |
| data_en_o | output | 1 | Pad drive-enable for data_o |
| dly_steer_o | output | 1 | Delayed-steering flag |

## Verification
Acceptance of a new tone and the expiry of the pause guard never coincide, because only one guard runs at a time. The collisions that matter are power-down against either of them. Power-down is asserted in the cycle a tone would be accepted. It is also asserted while the delayed-steering flag is still inside its two-cycle settling window. Inhibit is toggled in the cycle an extended key would complete its guard. A cycle-level reference model in the bench computes the latch and flag for every cycle of the random mix. The outputs are compared with that model each cycle, and directed sequences pin the exact edges of R2 to R5.

// File: rtl/dtmf_steer_pkg.sv
package dtmf_steer_pkg;

    typedef logic [3:0] key_code_t;

    localparam key_code_t KEY_EXT_A = 4'b1101;
    localparam key_code_t KEY_EXT_B = 4'b1110;
    localparam key_code_t KEY_EXT_C = 4'b1111;
    localparam key_code_t KEY_EXT_D = 4'b0000;

    // True for the four keys that the inhibit input hides.
    function automatic logic is_ext_key(key_code_t c);
        return (c == KEY_EXT_A) || (c == KEY_EXT_B) ||
               (c == KEY_EXT_C) || (c == KEY_EXT_D);
    endfunction

    typedef struct packed {
        logic      steer;
        key_code_t latch;
    } steer_state_t;

endpackage

// File: rtl/dtmf_key_qual.sv
module dtmf_key_qual
    import dtmf_steer_pkg::*;
(
    input  logic      det_i,
    input  key_code_t code_i,
    input  logic      inhibit_i,
    output logic      det_o
);

    always_comb begin
        det_o = det_i && !(inhibit_i && is_ext_key(code_i));
    end

endmodule

// File: rtl/dtmf_guard_timer.sv
module dtmf_guard_timer #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr_i,
    input  logic          run_i,
    input  logic [CW-1:0] limit_i,
    output logic          expire_o
);

    localparam int XW = CW + 1;

    logic [CW-1:0] cnt_d, cnt_q;
    logic [XW-1:0] next_len;

    always_comb begin
        next_len = {1'b0, cnt_q} + XW'(1);
        expire_o = run_i && !clr_i && (next_len >= {1'b0, limit_i});
        if (clr_i || !run_i || expire_o) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/dtmf_settle.sv
module dtmf_settle #(
    parameter int SETTLE = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic steer_d_i,
    input  logic steer_q_i,
    output logic dly_o
);

    localparam int SW = (SETTLE < 1) ? 1 : $clog2(SETTLE + 1);
    localparam logic [SW-1:0] TOP = SW'(SETTLE);

    logic [SW-1:0] age_d, age_q;

    always_comb begin
        if (!steer_d_i || !steer_q_i) begin
            age_d = '0;
        end else if (age_q == TOP) begin
            age_d = age_q;
        end else begin
            age_d = age_q + SW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            age_q <= '0;
        end else begin
            age_q <= age_d;
        end
    end

    assign dly_o = (age_q == TOP);

endmodule

// File: rtl/dtmf_steer.sv
module dtmf_steer
    import dtmf_steer_pkg::*;
#(
    parameter int CW     = 16,
    parameter int SETTLE = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          det_i,
    input  logic [3:0]    code_i,
    input  logic [CW-1:0] tone_guard_i,
    input  logic [CW-1:0] pause_guard_i,
    input  logic          inhibit_i,
    input  logic          pwr_dn_i,
    input  logic          out_en_i,
    output logic [3:0]    data_o,
    output logic          data_en_o,
    output logic          dly_steer_o
);

    steer_state_t  st_d, st_q;
    logic          det_eff;
    logic          run;
    logic [CW-1:0] limit;
    logic          expire;

    dtmf_key_qual u_qual (
        .det_i     (det_i),
        .code_i    (code_i),
        .inhibit_i (inhibit_i),
        .det_o     (det_eff)
    );

    always_comb begin
        // Idle: count tone presence. Registered: count tone absence.
        run   = st_q.steer ? !det_eff : det_eff;
        limit = st_q.steer ? pause_guard_i : tone_guard_i;
    end

    dtmf_guard_timer #(.CW(CW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_i    (pwr_dn_i),
        .run_i    (run),
        .limit_i  (limit),
        .expire_o (expire)
    );

    always_comb begin
        st_d = st_q;
        if (pwr_dn_i) begin
            st_d.steer = 1'b0;
        end else if (expire) begin
            st_d.steer = !st_q.steer;
            if (!st_q.steer) begin
                st_d.latch = code_i;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    dtmf_settle #(.SETTLE(SETTLE)) u_settle (
        .clk       (clk),
        .rst_n     (rst_n),
        .steer_d_i (st_d.steer),
        .steer_q_i (st_q.steer),
        .dly_o     (dly_steer_o)
    );

    assign data_en_o = out_en_i;
    assign data_o    = out_en_i ? st_q.latch : 4'b0000;

endmodule

// File: rtl/dtmf_steer_chk.sv
module dtmf_steer_chk
    import dtmf_steer_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       pwr_dn_i,
    input logic       inhibit_i,
    input logic       out_en_i,
    input logic [3:0] code_i,
    input logic       steer_i,
    input logic [3:0] latch_i,
    input logic       dly_i,
    input logic [3:0] data_i,
    input logic       data_en_i
);

    a_r2_latch_on_accept: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(latch_i) |-> $rose(steer_i));

    a_r3_settle_two: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dly_i) |-> ($past(steer_i, 2) && !$past(steer_i, 3)));

    a_r5_flag_needs_steer: assert property (@(posedge clk) disable iff (!rst_n)
        dly_i |-> steer_i);

    a_r6_no_ext_under_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(steer_i) |-> !($past(inhibit_i) && is_ext_key($past(code_i))));

    a_r7_bus_off: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en_i |-> (!data_en_i && data_i == 4'b0000));

    a_r7_bus_on: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_i |-> (data_en_i && data_i == latch_i));

    a_r8_pd_clears: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn_i |=> (!steer_i && !dly_i));

    a_r8_pd_keeps_latch: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_dn_i |=> $stable(latch_i));

endmodule

bind dtmf_steer dtmf_steer_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pwr_dn_i  (pwr_dn_i),
    .inhibit_i (inhibit_i),
    .out_en_i  (out_en_i),
    .code_i    (code_i),
    .steer_i   (st_q.steer),
    .latch_i   (st_q.latch),
    .dly_i     (dly_steer_o),
    .data_i    (data_o),
    .data_en_i (data_en_o)
);

// File: tb/dtmf_steer_test.sv
module dtmf_steer_test;

    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          det = 1'b0;
    logic [3:0]    code = 4'h0;
    logic [CW-1:0] tg = CW'(4);
    logic [CW-1:0] pg = CW'(3);
    logic          inh = 1'b0;
    logic          pd = 1'b0;
    logic          oe = 1'b1;
    logic [3:0]    data;
    logic          data_en;
    logic          dly;

    int total = 0;
    int fails = 0;
    bit auto_on = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dtmf_steer #(.CW(CW)) uut (
        .clk           (clk),
        .rst_n         (rst_n),
        .det_i         (det),
        .code_i        (code),
        .tone_guard_i  (tg),
        .pause_guard_i (pg),
        .inhibit_i     (inh),
        .pwr_dn_i      (pd),
        .out_en_i      (oe),
        .data_o        (data),
        .data_en_o     (data_en),
        .dly_steer_o   (dly)
    );

    // Reference model built from the requirements.
    bit       m_st = 0;
    int       m_cnt = 0;
    int       m_age = 0;
    bit [3:0] m_latch = 0;

    function automatic bit ext_key(bit [3:0] c);
        return c == 4'hD || c == 4'hE || c == 4'hF || c == 4'h0;
    endfunction

    function automatic int eff_lim(logic [CW-1:0] g);
        return (g == 0) ? 1 : int'(g);
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_age = 0; m_latch = 0;
        end else begin
            bit eff;
            eff = det && !(inh && ext_key(code));
            if (pd) begin
                m_st = 0; m_cnt = 0; m_age = 0;
            end else if (!m_st) begin
                if (eff) begin
                    if (m_cnt + 1 >= eff_lim(tg)) begin
                        m_st = 1; m_latch = code; m_cnt = 0; m_age = 0;
                    end else m_cnt++;
                end else m_cnt = 0;
            end else begin
                if (m_age < 2) m_age++;
                if (!eff) begin
                    if (m_cnt + 1 >= eff_lim(pg)) begin
                        m_st = 0; m_cnt = 0; m_age = 0;
                    end else m_cnt++;
                end else m_cnt = 0;
            end
        end
    end

    task automatic check(bit ok, string tag, int act, int exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-cycle comparison against the model (R2 data, R3 flag, R7 enable).
    always @(negedge clk) begin
        if (auto_on && rst_n) begin
            bit [3:0] exp_d;
            bit       exp_f;
            exp_d = oe ? m_latch : 4'h0;
            exp_f = m_st && (m_age == 2);
            check(data == exp_d, "R2 latch model", int'(data), int'(exp_d));
            check(dly == exp_f, "R3 flag model", int'(dly), int'(exp_f));
            check(data_en == oe, "R7 enable model", int'(data_en), int'(oe));
        end
    end

    task automatic drive(bit d, bit [3:0] c, int n);
        det = d;
        code = c;
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        auto_on = 1'b1;
        @(negedge clk);
        check(data == 4'h0, "R9 latch", int'(data), 0);
        check(dly == 1'b0, "R9 flag", int'(dly), 0);

        drive(1, 4'h5, 3);
        drive(0, 4'h5, 1);
        check(data == 4'h0, "R1 short tone", int'(data), 0);
        check(dly == 1'b0, "R1 flag", int'(dly), 0);

        drive(1, 4'h5, 4);
        check(data == 4'h5, "R2 accept", int'(data), 5);
        check(dly == 1'b0, "R3 settle 0", int'(dly), 0);
        drive(1, 4'h5, 1);
        check(dly == 1'b0, "R3 settle 1", int'(dly), 0);
        drive(1, 4'h5, 1);
        check(dly == 1'b1, "R3 settle 2", int'(dly), 1);

        drive(0, 4'h5, 2);
        check(dly == 1'b1, "R4 dropout", int'(dly), 1);
        drive(1, 4'h9, 3);
        check(data == 4'h5, "R4 no new code", int'(data), 5);

        drive(0, 4'h9, 3);
        check(dly == 1'b0, "R5 pause", int'(dly), 0);
        drive(1, 4'h9, 4);
        check(data == 4'h9, "R5 next tone", int'(data), 9);
        drive(0, 4'h9, 3);

        inh = 1'b1;
        drive(1, 4'hD, 8);
        check(data == 4'h9, "R6 inhibited", int'(data), 9);
        check(dly == 1'b0, "R6 flag", int'(dly), 0);
        drive(0, 4'hD, 1);
        drive(1, 4'h3, 4);
        check(data == 4'h3, "R6 normal key", int'(data), 3);
        drive(0, 4'h3, 3);
        inh = 1'b0;

        oe = 1'b0;
        drive(0, 4'h3, 1);
        check(data_en == 1'b0 && data == 4'h0, "R7 off", int'(data), 0);
        oe = 1'b1;
        drive(0, 4'h3, 1);
        check(data_en == 1'b1 && data == 4'h3, "R7 on", int'(data), 3);

        drive(1, 4'h0, 4);
        check(data == 4'h0, "R6 key D", int'(data), 0);
        drive(0, 4'h0, 3);

        drive(1, 4'h7, 6);
        check(dly == 1'b1, "R8 before", int'(dly), 1);
        pd = 1'b1;
        drive(1, 4'h7, 1);
        check(dly == 1'b0, "R8 flag clear", int'(dly), 0);
        check(data == 4'h7, "R8 latch kept", int'(data), 7);
        drive(1, 4'h2, 6);
        check(data == 4'h7, "R8 no accept", int'(data), 7);
        pd = 1'b0;
        drive(0, 4'h2, 1);

        tg = '0;
        pg = '0;
        drive(1, 4'h6, 1);
        check(data == 4'h6, "R10 tone zero", int'(data), 6);
        drive(0, 4'h6, 1);
        drive(1, 4'h8, 1);
        check(data == 4'h8, "R10 pause zero", int'(data), 8);
        drive(0, 4'h8, 2);

        for (int seg = 0; seg < 400; seg++) begin
            if (seg % 40 == 0) begin
                tg = CW'($urandom_range(0, 6));
                pg = CW'($urandom_range(0, 6));
            end
            inh = ($urandom_range(0, 3) == 0);
            oe  = ($urandom_range(0, 7) != 0);
            pd  = ($urandom_range(0, 15) == 0);
            drive(1, 4'($urandom_range(0, 15)), $urandom_range(1, 9));
            if ($urandom_range(0, 5) == 0) pd = 1'b1;
            drive(0, code, $urandom_range(1, 9));
            pd = 1'b0;
        end

        finish_run();
    end

endmodule